// File: doc/BRIEF.md
# Receive Frame Slip Buffer

This block is a two-frame elastic store placed between a recovered line byte stream and the system byte stream. The write side stores one byte per write strobe and the read side fetches one byte per read strobe. Each side also has its own frame-start pulse. Both sides run in a single clock domain, and the strobes set the two rates. When the two rates drift apart, the store absorbs the wander. The slack it allows is one frame's worth of slots on either side of the nominal half-buffer delay.

The delay is the write position minus the read position, modulo the buffer size. If the delay shrinks to almost nothing, or grows to nearly the whole buffer, the block arms a controlled slip. The slip is carried out at the next read frame start. At that point the read position moves by one frame, so a complete frame is either repeated or discarded, and the delay shifts by half the buffer.

A small status port reports slips. It exposes a toggle bit that changes on every slip, a direction bit and a pending-event bit. The event bit drives an interrupt that a mask input can suppress, and reading the status clears the event.

Top module: `rx_slip_buffer`

## Requirements
- R1: After reset, stat_q, irq and rd_valid are all 0. The write position is one frame (32 slots) ahead of the read position, with the read position at slot 0 of frame 0.
- R2: A read strobe returns the byte stored at the read position on rd_data one cycle later, with rd_valid high for that cycle. If the same slot is written in the same cycle, the read returns the previous content.
- R3: A write strobe stores wr_data at the write position. Each strobe advances its own position by one, and positions wrap within the 64 slots.
- R4: A frame-start pulse on either side moves that side's position to the first slot of the next frame. If the position is already on slot 0, it does not move. A frame-start pulse takes priority over a strobe in the same cycle.
- R5: When the delay (write position minus read position, mod 64) is below 2 and no slip is armed, an underflow slip is armed.
- R6: When the delay is above 62 and no slip is armed, an overflow slip is armed.
- R7: An armed slip takes effect only on a read frame start. There the read position goes to slot 0 of the frame other than the one frame alignment would give, so one whole frame is repeated or dropped.
- R8: stat_q[0] toggles on every slip that takes effect. stat_q[1] then holds the direction of that slip: 1 means underflow (frame repeated) and 0 means overflow (frame lost).
- R9: stat_q[2] is set when a slip takes effect and is cleared by a stat_rd pulse. If both happen in the same cycle, the bit is set.
- R10: irq equals stat_q[2] AND NOT irq_mask.
- R11: While a slip is armed, no other condition changes its direction until it has taken effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | Write byte strobe |
| wr_fs | input | 1 | Write frame start |
| wr_data | input | 8 | Byte to store |
| rd_stb | input | 1 | Read byte strobe |
| rd_fs | input | 1 | Read frame start |
| rd_data | output | 8 | Byte read out |
| rd_valid | output | 1 | rd_data holds a fresh byte |
| stat_rd | input | 1 | Status read pulse; clears the event bit |
| irq_mask | input | 1 | High suppresses irq |
| stat_q | output | 3 | {event, direction, toggle} |
| irq | output | 1 | Slip interrupt |

## Verification
A slip can take effect in the same cycle that software reads the status. The event bit must then end up set and not cleared. During the phase where the reader runs faster than the writer, the bench drives stat_rd high on every read frame start while its model has a slip armed. It then checks stat_q[2] after that edge, and a cycle-accurate reference model judges every output on every cycle.

// File: rtl/sb_pkg.sv
package sb_pkg;
   typedef struct packed {
      logic evt;
      logic dir;
      logic tgl;
   } slip_stat_t;

   localparam logic DIR_LOST     = 1'b0;
   localparam logic DIR_REPEATED = 1'b1;
endpackage

// File: rtl/sb_ptr.sv
module sb_ptr #(
   parameter int SLOT_W = 5,
   parameter int AW     = SLOT_W + 1,
   parameter logic [AW-1:0] RST_VAL = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          stb,
   input  logic          fs,
   input  logic          flip,
   output logic [AW-1:0] ptr
);
   localparam logic [AW-1:0] SLOT_MASK = AW'((1 << SLOT_W) - 1);

   logic          at_edge;
   logic [AW-1:0] aligned;

   if (AW != SLOT_W + 1) begin : g_bad_aw
      $error("sb_ptr: AW must be SLOT_W+1");
   end

   assign at_edge = (ptr[SLOT_W-1:0] == '0);
   assign aligned = at_edge ? ptr : ((ptr | SLOT_MASK) + AW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr <= RST_VAL;
      end else if (fs) begin
         ptr <= {aligned[AW-1] ^ flip, aligned[SLOT_W-1:0]};
      end else if (stb) begin
         ptr <= ptr + AW'(1);
      end
   end
endmodule

// File: rtl/sb_store.sv
module sb_store #(
   parameter int DATA_W = 8,
   parameter int AW     = 6,
   localparam int DEPTH = 1 << AW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
      if (rd_en) rd_data <= mem[rd_addr];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rd_valid <= 1'b0;
      else        rd_valid <= rd_en;
   end
endmodule

// File: rtl/sb_slip_ctl.sv
module sb_slip_ctl
   import sb_pkg::*;
#(
   parameter int AW     = 6,
   parameter int LO_LIM = 2,
   parameter int HI_LIM = 62
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] wr_ptr,
   input  logic [AW-1:0] rd_ptr,
   input  logic          rd_fs,
   input  logic          stat_rd,
   input  logic          irq_mask,
   output logic          slip_now,
   output slip_stat_t    stat,
   output logic          irq
);
   logic [AW-1:0] delay;
   logic          armed;
   logic          armed_dir;
   logic          near_hit;
   logic          far_hit;

   if (LO_LIM < 1 || HI_LIM >= (1 << AW) || LO_LIM >= HI_LIM) begin : g_bad_lim
      $error("sb_slip_ctl: limits out of range");
   end

   assign delay    = wr_ptr - rd_ptr;
   assign near_hit = (delay < AW'(LO_LIM));
   assign far_hit  = (delay > AW'(HI_LIM));
   assign slip_now = rd_fs & armed;
   assign irq      = stat.evt & ~irq_mask;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed     <= 1'b0;
         armed_dir <= DIR_LOST;
         stat.tgl  <= 1'b0;
         stat.dir  <= 1'b0;
      end else if (slip_now) begin
         armed    <= 1'b0;
         stat.tgl <= ~stat.tgl;
         stat.dir <= armed_dir;
      end else if (!armed && near_hit) begin
         armed     <= 1'b1;
         armed_dir <= DIR_REPEATED;
      end else if (!armed && far_hit) begin
         armed     <= 1'b1;
         armed_dir <= DIR_LOST;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        stat.evt <= 1'b0;
      else if (slip_now) stat.evt <= 1'b1;
      else if (stat_rd)  stat.evt <= 1'b0;
   end
endmodule

// File: rtl/rx_slip_buffer.sv
module rx_slip_buffer
   import sb_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int SLOTS  = 32,
   parameter int LO_LIM = 2,
   parameter int HI_LIM = 62
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic              wr_fs,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_stb,
   input  logic              rd_fs,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   input  logic              stat_rd,
   input  logic              irq_mask,
   output logic [2:0]        stat_q,
   output logic              irq
);
   localparam int SLOT_W = $clog2(SLOTS);
   localparam int AW     = SLOT_W + 1;
   localparam logic [AW-1:0] WR_RST = AW'(SLOTS);
   localparam logic [AW-1:0] RD_RST = '0;

   logic [AW-1:0] wr_ptr;
   logic [AW-1:0] rd_ptr;
   logic          slip_now;
   slip_stat_t    stat;

   if ((1 << SLOT_W) != SLOTS) begin : g_bad_slots
      $error("rx_slip_buffer: SLOTS must be a power of two");
   end

   sb_ptr #(.SLOT_W(SLOT_W), .AW(AW), .RST_VAL(WR_RST)) u_wr_ptr (
      .clk(clk), .rst_n(rst_n), .stb(wr_stb), .fs(wr_fs), .flip(1'b0), .ptr(wr_ptr)
   );

   sb_ptr #(.SLOT_W(SLOT_W), .AW(AW), .RST_VAL(RD_RST)) u_rd_ptr (
      .clk(clk), .rst_n(rst_n), .stb(rd_stb), .fs(rd_fs), .flip(slip_now), .ptr(rd_ptr)
   );

   sb_store #(.DATA_W(DATA_W), .AW(AW)) u_store (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_stb & ~wr_fs), .wr_addr(wr_ptr), .wr_data(wr_data),
      .rd_en(rd_stb & ~rd_fs), .rd_addr(rd_ptr),
      .rd_data(rd_data), .rd_valid(rd_valid)
   );

   sb_slip_ctl #(.AW(AW), .LO_LIM(LO_LIM), .HI_LIM(HI_LIM)) u_ctl (
      .clk(clk), .rst_n(rst_n), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
      .rd_fs(rd_fs), .stat_rd(stat_rd), .irq_mask(irq_mask),
      .slip_now(slip_now), .stat(stat), .irq(irq)
   );

   assign stat_q = stat;
endmodule

// File: rtl/rx_slip_buffer_chk.sv
module rx_slip_buffer_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       rd_fs,
   input logic       rd_stb,
   input logic       rd_valid,
   input logic       irq_mask,
   input logic       irq,
   input logic [2:0] stat_q
);
   AST_SLIP_AT_FS: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(stat_q[0]) |-> $past(rd_fs)); // R7
   AST_SLIP_SETS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(stat_q[0]) |-> stat_q[2]); // R9
   AST_DIR_WITH_TGL: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(stat_q[0]) |-> $stable(stat_q[1])); // R8
   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      irq_mask |-> !irq); // R10
   AST_IRQ_NEEDS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> stat_q[2]); // R10
   AST_VALID_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(rd_stb)); // R2
endmodule

bind rx_slip_buffer rx_slip_buffer_chk u_chk (
   .clk(clk), .rst_n(rst_n), .rd_fs(rd_fs), .rd_stb(rd_stb), .rd_valid(rd_valid),
   .irq_mask(irq_mask), .irq(irq), .stat_q(stat_q)
);

// File: tb/rx_slip_buffer_tb.sv
module rx_slip_buffer_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_stb = 0, wr_fs = 0, rd_stb = 0, rd_fs = 0, stat_rd = 0, irq_mask = 0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       rd_valid, irq;
   logic [2:0] stat_q;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   // reference model state
   logic [7:0] m_mem [64];
   bit         m_wr [64];
   int         m_wp, m_rp;
   bit         m_pend, m_pdir, m_tgl, m_dir, m_evt;
   bit         e_valid, e_known, e_both;
   logic [7:0] e_data;
   int         wcnt, rcnt;

   rx_slip_buffer u_dut (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_fs(wr_fs), .wr_data(wr_data),
      .rd_stb(rd_stb), .rd_fs(rd_fs), .rd_data(rd_data), .rd_valid(rd_valid),
      .stat_rd(stat_rd), .irq_mask(irq_mask), .stat_q(stat_q), .irq(irq)
   );

   always #10 clk = ~clk;

   function automatic int f_align(int p);
      return (p % 32 == 0) ? p : (((p / 32) + 1) * 32) % 64;
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_wp = 32; m_rp = 0;
      m_pend = 0; m_pdir = 0; m_tgl = 0; m_dir = 0; m_evt = 0;
      e_valid = 0; e_known = 0; e_both = 0;
      for (int i = 0; i < 64; i++) m_wr[i] = 0;
      wcnt = 0; rcnt = 0;
   endtask

   task automatic model_edge();
      int  d;
      bit  sn;
      d  = (m_wp - m_rp) & 63;
      sn = rd_fs && m_pend;
      e_both  = sn && stat_rd;
      e_valid = rd_stb && !rd_fs;
      if (e_valid) begin
         e_data  = m_mem[m_rp];
         e_known = m_wr[m_rp];
      end
      if (wr_stb && !wr_fs) begin
         m_mem[m_wp] = wr_data;
         m_wr[m_wp]  = 1;
      end
      if (wr_fs) m_wp = f_align(m_wp);
      else if (wr_stb) m_wp = (m_wp + 1) & 63;
      if (rd_fs) m_rp = f_align(m_rp) ^ (sn ? 32 : 0);
      else if (rd_stb) m_rp = (m_rp + 1) & 63;
      if (sn) begin
         m_pend = 0; m_tgl = !m_tgl; m_dir = m_pdir;
      end else if (!m_pend && d < 2) begin
         m_pend = 1; m_pdir = 1;
      end else if (!m_pend && d > 62) begin
         m_pend = 1; m_pdir = 0;
      end
      if (sn) m_evt = 1;
      else if (stat_rd) m_evt = 0;
   endtask

   task automatic compare();
      check(rd_valid == e_valid, "R2 valid", rd_valid, e_valid);
      if (e_valid && e_known)
         check(rd_data == e_data, "R2 R3 R4 R7 data", rd_data, e_data);
      check(stat_q[1:0] == {m_dir, m_tgl}, "R5 R6 R8 R11 dir/tgl", stat_q[1:0], {m_dir, m_tgl});
      check(stat_q[2] == m_evt, "R9 event", stat_q[2], m_evt);
      check(irq == (m_evt && !irq_mask), "R10 irq", irq, m_evt && !irq_mask);
      if (e_both) check(stat_q[2] == 1'b1, "R9 set wins over read", stat_q[2], 1);
   endtask

   task automatic step(int wrate, int rrate, bit force_rd);
      @(negedge clk);
      compare();
      wr_stb = 0; wr_fs = 0; rd_stb = 0; rd_fs = 0; stat_rd = 0;
      wr_data = 8'($urandom);
      if (wcnt == 32 || (wcnt > 0 && $urandom % 64 == 0)) begin
         wr_fs = 1; wcnt = 0;
      end else if ($urandom % 4 < wrate) begin
         wr_stb = 1; wcnt++;
      end
      if (rcnt == 32 || (rcnt > 0 && $urandom % 64 == 0)) begin
         rd_fs = 1; rcnt = 0;
      end else if ($urandom % 4 < rrate) begin
         rd_stb = 1; rcnt++;
      end
      stat_rd = ($urandom % 16 == 0) || (force_rd && rd_fs && m_pend);
      @(posedge clk);
      model_edge();
   endtask

   initial begin
      #(20 * 150000);
      $display("FAIL watchdog expired");
      errors++;
      checks++;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd20250));
      model_reset();
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      // R1: reset state
      check(stat_q == 3'b000, "R1 stat", stat_q, 0);
      check(irq == 1'b0, "R1 irq", irq, 0);
      check(rd_valid == 1'b0, "R1 valid", rd_valid, 0);
      // phase A: matched rates, mask toggled
      for (int k = 0; k < 6; k++) begin
         irq_mask = k[0];
         repeat (500) step(2, 2, 0);
      end
      // phase B: reader faster -> underflow slips, forced collisions with status read
      irq_mask = 0;
      repeat (4000) step(2, 3, 1);
      // phase C: writer faster -> overflow slips, masked
      irq_mask = 1;
      repeat (4000) step(3, 2, 0);
      irq_mask = 0;
      repeat (1000) step(2, 2, 1);
      @(negedge clk);
      compare();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule